// File: doc/BRIEF.md
# E1 Line Error Counter Bank

The block keeps three 16-bit performance-monitoring counts for an E1 receiver: line code (bipolar) violations, errored CRC4 words, and far-end block errors reported through the E-bits of the CRC4 multiframe. Upstream line decoding and framing logic drive single-cycle event strobes and level sync-loss flags into it. Each counter applies its own qualifying rule to these inputs before it counts.

A one-cycle one-second strobe ends the measurement interval. On that strobe every running count is copied into a readable holding register and the running count restarts in the same cycle. Software reads the holding registers one byte at a time through a synchronous read port. The bipolar violation count stops at its maximum value. The other two counts are plain incrementers, because their event rate cannot fill 16 bits within one second.

Top module: `e1_err_counter_bank`

## Requirements
- R1: After reset, all running counts and holding registers are zero, and `rd_data` is 0x00.
- R2: The bipolar violation count adds one for each cycle with `bpv_pulse` high, unless R3 suppresses it.
- R3: While `hdb3_mode` is 1, a `bpv_pulse` with `bpv_hdb3_cw` high is not counted. While `hdb3_mode` is 0, `bpv_hdb3_cw` has no effect.
- R4: The bipolar violation count stops at 0xFFFF and does not wrap to zero.
- R5: The bipolar violation count ignores `fas_loss`, `crc_mf_loss` and `cas_loss`.
- R6: The CRC4 count adds one for each cycle with `crc_err_pulse` high. It does not count in a cycle where `fas_loss` or `crc_mf_loss` is high.
- R7: `cas_loss` alone suspends neither the CRC4 count nor the E-bit count.
- R8: The E-bit count adds one in a cycle where all of these hold: `ebit_valid` is 1, `ebit_value` is 0, `frame_num` (0 to 15 within the multiframe) is 13 or 15, and neither `fas_loss` nor `crc_mf_loss` is high.
- R9: In a cycle with `sec_tick` high, each holding register takes the running count as it was before that cycle. Each running count restarts at 1 if an event qualifies in that cycle, and at 0 otherwise.
- R10: `rd_data` is updated at the clock edge where `rd_en` is high and holds its value otherwise. The address map is: 0x00/0x01 bipolar violations, 0x02/0x03 CRC4, 0x04/0x05 E-bit. The even address returns bits 15:8 and the odd address returns bits 7:0 of the holding register.
- R11: A read of any address above 0x05 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdb3_mode | input | 1 | Receive side is set to HDB3 decoding |
| bpv_pulse | input | 1 | One bipolar violation seen this cycle |
| bpv_hdb3_cw | input | 1 | The violation belongs to an HDB3 substitution code word |
| crc_err_pulse | input | 1 | One errored CRC4 word seen this cycle |
| ebit_valid | input | 1 | `ebit_value` and `frame_num` are valid this cycle |
| ebit_value | input | 1 | First bit of the received frame |
| frame_num | input | 4 | Frame number within the CRC4 multiframe |
| fas_loss | input | 1 | Frame alignment lost |
| crc_mf_loss | input | 1 | CRC4 multiframe alignment lost |
| cas_loss | input | 1 | CAS multiframe alignment lost |
| sec_tick | input | 1 | One-second interval strobe |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 8 | Read data, registered |

## Verification
The bench drives an event arriving in the same cycle as the one-second strobe. A design that let that event land in the snapshot, or dropped it, would read back one more or one fewer than expected. It holds the violation strobe high for more than 65,536 cycles without a strobe, so a counter that wrapped would report a small number where 0xFFFF is expected. The bench mixes HDB3 code-word flags with the mode bit off and on, and runs CAS-only loss next to FAS and multiframe loss. This catches gates applied to the wrong counter or the wrong loss level. It also presents E-bits in frames other than 13 and 15 and reads the unmapped addresses, which would expose a loose frame or address decode.

// File: rtl/e1pm_pkg.sv
package e1pm_pkg;
   localparam int BYTE_W = 8;
   localparam int NCH    = 3;

   typedef enum int {
      CH_BPV  = 0,
      CH_CRC  = 1,
      CH_EBIT = 2
   } chan_e;

   // channels whose count stops at full scale instead of wrapping
   localparam logic [NCH-1:0] SAT_MASK = 3'b001;

   // frames of the CRC4 multiframe that carry far-end block error bits
   localparam int EBIT_FRAME_A = 13;
   localparam int EBIT_FRAME_B = 15;
endpackage

// File: rtl/e1pm_event_gate.sv
module e1pm_event_gate
   import e1pm_pkg::*;
#(
   parameter int FRAME_W = 4
) (
   input  logic               hdb3_mode,
   input  logic               bpv_pulse,
   input  logic               bpv_hdb3_cw,
   input  logic               crc_err_pulse,
   input  logic               ebit_valid,
   input  logic               ebit_value,
   input  logic [FRAME_W-1:0] frame_num,
   input  logic               fas_loss,
   input  logic               crc_mf_loss,
   output logic [NCH-1:0]     inc
);
   logic align_ok;
   logic ebit_slot;

   if (FRAME_W < 4) begin : g_bad_frame_w
      $error("e1pm_event_gate: FRAME_W must cover frame numbers up to 15");
   end

   // CAS-level loss is deliberately not part of this qualifier
   assign align_ok  = !fas_loss && !crc_mf_loss;
   assign ebit_slot = (frame_num == FRAME_W'(EBIT_FRAME_A)) ||
                      (frame_num == FRAME_W'(EBIT_FRAME_B));

   always_comb begin
      inc          = '0;
      inc[CH_BPV]  = bpv_pulse && !(hdb3_mode && bpv_hdb3_cw);
      inc[CH_CRC]  = crc_err_pulse && align_ok;
      inc[CH_EBIT] = ebit_valid && !ebit_value && ebit_slot && align_ok;
   end
endmodule

// File: rtl/e1pm_counter.sv
module e1pm_counter #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             snap,
   output logic [CNT_W-1:0] live_q,
   output logic [CNT_W-1:0] hold_q
);
   localparam logic [CNT_W-1:0] FULL = '1;

   logic [CNT_W-1:0] bumped;
   logic [CNT_W-1:0] live_d;

   if (CNT_W < 2) begin : g_bad_width
      $error("e1pm_counter: CNT_W must be at least 2");
   end

   if (SATURATE) begin : g_sat
      assign bumped = (live_q == FULL) ? live_q : live_q + CNT_W'(1);
   end else begin : g_wrap
      assign bumped = live_q + CNT_W'(1);
   end

   always_comb begin
      if (snap)      live_d = inc ? CNT_W'(1) : '0;
      else if (inc)  live_d = bumped;
      else           live_d = live_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
         hold_q <= '0;
      end else begin
         live_q <= live_d;
         if (snap) hold_q <= live_q;
      end
   end

   // R9
   snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap |=> hold_q == $past(live_q));

   // R9
   snap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snap && !inc) |=> live_q == '0);

   if (SATURATE) begin : g_sat_chk
      // R4
      sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!snap && live_q == FULL) |=> live_q == FULL);
   end
endmodule

// File: rtl/e1pm_read_port.sv
module e1pm_read_port
   import e1pm_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    rd_addr,
   input  logic [NCH*CNT_W-1:0] hold_flat,
   output logic [BYTE_W-1:0]    rd_data
);
   localparam int NBYTES = 2 * NCH;

   logic [BYTE_W-1:0] sel_byte;

   if (CNT_W != 2 * BYTE_W) begin : g_bad_cnt_w
      $error("e1pm_read_port: each counter must span exactly two bytes");
   end
   if ((1 << ADDR_W) < NBYTES) begin : g_bad_addr_w
      $error("e1pm_read_port: ADDR_W too narrow for the register map");
   end

   always_comb begin
      sel_byte = '0;
      for (int c = 0; c < NCH; c++) begin
         if (rd_addr[ADDR_W-1:1] == (ADDR_W-1)'(c)) begin
            sel_byte = rd_addr[0] ? hold_flat[c*CNT_W +: BYTE_W]
                                  : hold_flat[c*CNT_W + BYTE_W +: BYTE_W];
         end
      end
      if (rd_addr >= ADDR_W'(NBYTES)) sel_byte = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= sel_byte;
   end

   // R10
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R11
   rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr >= ADDR_W'(NBYTES)) |=> rd_data == '0);
endmodule

// File: rtl/e1_err_counter_bank.sv
module e1_err_counter_bank
   import e1pm_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int ADDR_W  = 8,
   parameter int FRAME_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hdb3_mode,
   input  logic               bpv_pulse,
   input  logic               bpv_hdb3_cw,
   input  logic               crc_err_pulse,
   input  logic               ebit_valid,
   input  logic               ebit_value,
   input  logic [FRAME_W-1:0] frame_num,
   input  logic               fas_loss,
   input  logic               crc_mf_loss,
   input  logic               cas_loss,
   input  logic               sec_tick,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [7:0]         rd_data
);
   logic [NCH-1:0]       inc;
   logic [CNT_W-1:0]     live_w [NCH];
   logic [CNT_W-1:0]     hold_w [NCH];
   logic [NCH*CNT_W-1:0] hold_flat;

   if (BYTE_W != 8) begin : g_bad_byte
      $error("e1_err_counter_bank: read port is byte wide");
   end

   e1pm_event_gate #(.FRAME_W(FRAME_W)) u_gate (
      .hdb3_mode    (hdb3_mode),
      .bpv_pulse    (bpv_pulse),
      .bpv_hdb3_cw  (bpv_hdb3_cw),
      .crc_err_pulse(crc_err_pulse),
      .ebit_valid   (ebit_valid),
      .ebit_value   (ebit_value),
      .frame_num    (frame_num),
      .fas_loss     (fas_loss),
      .crc_mf_loss  (crc_mf_loss),
      .inc          (inc)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      e1pm_counter #(.CNT_W(CNT_W), .SATURATE(SAT_MASK[c])) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (inc[c]),
         .snap  (sec_tick),
         .live_q(live_w[c]),
         .hold_q(hold_w[c])
      );
      assign hold_flat[c*CNT_W +: CNT_W] = hold_w[c];
   end

   e1pm_read_port #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .hold_flat(hold_flat),
      .rd_data  (rd_data)
   );

   // R3
   hdb3_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdb3_mode && bpv_hdb3_cw && !sec_tick) |=> $stable(live_w[CH_BPV]));

   // R5
   bpv_loss_blind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bpv_pulse && !bpv_hdb3_cw && !sec_tick && live_w[CH_BPV] < 16'hFFFE
       && (fas_loss || crc_mf_loss || cas_loss))
      |=> live_w[CH_BPV] == $past(live_w[CH_BPV]) + CNT_W'(1));

   // R6
   crc_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((fas_loss || crc_mf_loss) && !sec_tick) |=> $stable(live_w[CH_CRC]));

   // R7
   cas_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_loss && !fas_loss && !crc_mf_loss && crc_err_pulse && !sec_tick)
      |=> live_w[CH_CRC] == $past(live_w[CH_CRC]) + CNT_W'(1));

   // R8
   ebit_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((fas_loss || crc_mf_loss || !ebit_valid) && !sec_tick)
      |=> $stable(live_w[CH_EBIT]));
endmodule

// File: tb/e1_err_counter_bank_bench.sv
module e1_err_counter_bank_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hdb3_mode = 0, bpv_pulse = 0, bpv_hdb3_cw = 0, crc_err_pulse = 0;
   logic       ebit_valid = 0, ebit_value = 1;
   logic [3:0] frame_num = '0;
   logic       fas_loss = 0, crc_mf_loss = 0, cas_loss = 0, sec_tick = 0;
   logic       rd_en = 0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;

   always #5 clk = ~clk;

   e1_err_counter_bank u_e1_err_counter_bank (
      .clk(clk), .rst_n(rst_n), .hdb3_mode(hdb3_mode), .bpv_pulse(bpv_pulse),
      .bpv_hdb3_cw(bpv_hdb3_cw), .crc_err_pulse(crc_err_pulse),
      .ebit_valid(ebit_valid), .ebit_value(ebit_value), .frame_num(frame_num),
      .fas_loss(fas_loss), .crc_mf_loss(crc_mf_loss), .cas_loss(cas_loss),
      .sec_tick(sec_tick), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   string phase = "R1";
   string addr_tag = "R10";
   bit done = 0;

   // reference model: live[0..2] and held[0..2], channel order bpv, crc, ebit
   int live [3] = '{0, 0, 0};
   int held [3] = '{0, 0, 0};
   int exp_rd = 0;

   function automatic int byte_of(int a);
      if (a > 5) return 0;
      return (a % 2 == 0) ? (held[a/2] >> 8) & 255 : held[a/2] & 255;
   endfunction

   always @(posedge clk) begin
      bit ev [3];
      if (!rst_n) begin
         foreach (live[i]) begin live[i] = 0; held[i] = 0; end
         exp_rd = 0;
      end else begin
         ev[0] = bpv_pulse && !(hdb3_mode && bpv_hdb3_cw);
         ev[1] = crc_err_pulse && !fas_loss && !crc_mf_loss;
         ev[2] = ebit_valid && !ebit_value && (frame_num == 13 || frame_num == 15)
                 && !fas_loss && !crc_mf_loss;
         if (rd_en) exp_rd = byte_of(int'(rd_addr));
         for (int i = 0; i < 3; i++) begin
            if (sec_tick) begin
               held[i] = live[i];
               live[i] = ev[i] ? 1 : 0;
            end else if (ev[i]) begin
               if (i == 0) live[i] = (live[i] == 65535) ? 65535 : live[i] + 1;
               else        live[i] = (live[i] + 1) & 16'hFFFF;
            end
         end
      end
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: rd_data=0x%02h expected 0x%02h at cycle %0d",
                  req, act, exp, cycles);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         cycles++;
         if (!rst_n) check("R1", int'(rd_data), 0);
         else        check({phase, " ", addr_tag}, int'(rd_data), exp_rd);
         if (cycles > 190000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
         end
      end
   end

   // background reader: sweeps addresses 0..7, idles every fifth cycle
   always @(negedge clk) begin
      if (rst_n) begin
         rd_en <= (cycles % 5 != 0);
         if (cycles % 5 != 0) begin
            rd_addr <= (rd_addr + 8'd1) & 8'd7;
            case ((int'(rd_addr) + 1) % 8)
               0, 1:    addr_tag <= "R2";
               2, 3:    addr_tag <= "R6";
               4, 5:    addr_tag <= "R8";
               default: addr_tag <= "R11";
            endcase
         end else begin
            addr_tag <= "R10";
         end
      end
   end

   task automatic rand_cycle(int tick_div, bit losses);
      @(negedge clk);
      bpv_pulse     <= ($urandom % 3 == 0);
      bpv_hdb3_cw   <= ($urandom % 2 == 0);
      crc_err_pulse <= ($urandom % 3 == 0);
      ebit_valid    <= ($urandom % 2 == 0);
      ebit_value    <= ($urandom % 2 == 0);
      frame_num     <= ($urandom % 2 == 0) ? 4'(12 + $urandom % 4) : 4'($urandom);
      fas_loss      <= losses && ($urandom % 5 == 0);
      crc_mf_loss   <= losses && ($urandom % 5 == 0);
      cas_loss      <= losses && ($urandom % 2 == 0);
      sec_tick      <= ($urandom % tick_div == 0);
   endtask

   task automatic idle_inputs();
      @(negedge clk);
      bpv_pulse <= 0; crc_err_pulse <= 0; ebit_valid <= 0;
      fas_loss <= 0; crc_mf_loss <= 0; cas_loss <= 0; sec_tick <= 0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      phase = "R2";
      hdb3_mode <= 0;
      for (int k = 0; k < 3000; k++) rand_cycle(60, 0);

      phase = "R3";
      hdb3_mode <= 1;
      for (int k = 0; k < 3000; k++) rand_cycle(60, 0);

      phase = "R5 R7";
      for (int k = 0; k < 4000; k++) rand_cycle(60, 1);

      phase = "R9";
      for (int k = 0; k < 2000; k++) rand_cycle(4, 1);

      // saturation: continuous violations with no interval strobe
      phase = "R4";
      idle_inputs();
      @(negedge clk);
      hdb3_mode <= 0; bpv_hdb3_cw <= 0; bpv_pulse <= 1; sec_tick <= 1;
      @(negedge clk);
      sec_tick <= 0;
      repeat (65600) @(negedge clk);
      sec_tick <= 1;
      @(negedge clk);
      sec_tick <= 0; bpv_pulse <= 0;
      repeat (20) @(negedge clk);
      if (held[0] != 65535) begin
         fails++;
         $display("FAIL R4: model hold=%0d expected 65535", held[0]);
      end
      checks++;

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule